// File: doc/BRIEF.md
# Keyboard Row Interrupt and Wakeup Logic

This block watches the row lines of a keyboard matrix and turns them into two signals: a level-sensitive keyboard interrupt request for the interrupt controller and a single-cycle wakeup request for the power controller. Each row line passes through a two-flop synchronizer. The synchronized rows are then OR-combined into one "key active" signal. A small control register selects how many rows take part, all eight or only the low six, and whether direct wakeup is enabled.

Direct wakeup lets a key press bring the system out of its power-saving state even when the keyboard interrupt is masked. In that case no interrupt is raised, and execution resumes where it stopped. When the interrupt is unmasked, the interrupt request is raised along with the wakeup, so the key press is serviced. With direct wakeup disabled, only an unmasked keyboard interrupt can wake the system.

Top module: `kbd_wake_ctrl`

## Requirements
- R1: After reset both control bits are zero, and a read returns all zeros.
- R2: With the six-row bit (register bit 0) at 0, the interrupt request is the OR of all eight synchronized row inputs, gated by the interrupt enable.
- R3: With the six-row bit at 1, only rows 0 to 5 take part. Activity on rows 6 and 7 raises neither the interrupt nor the wakeup.
- R4: Rows are active high. The interrupt request is a level that follows the enabled rows, and it stays low while the interrupt enable input is 0.
- R5: With direct wakeup (register bit 1) at 1 and the system in power saving, a rise of the enabled-row OR pulses the wakeup whatever the interrupt enable. With the interrupt masked, the interrupt request stays low.
- R6: With direct wakeup at 1 and the interrupt unmasked, the same rise raises both the wakeup pulse and the interrupt request.
- R7: With direct wakeup at 0, a wakeup is produced only by a rise of the unmasked interrupt request.
- R8: The wakeup is a one-cycle pulse, and it is never asserted while the power state input shows the operating state.
- R9: A write with the write enable set updates the control bits at the next clock edge. A read returns bit 0 as six-row and bit 1 as direct wakeup, with bits 7 to 2 as zero.
- R10: A change on the row inputs reaches the outputs after two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_i | input | 8 | Keyboard row lines, active high, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| irq_en_i | input | 1 | Keyboard interrupt enable (1 = unmasked) |
| low_power_i | input | 1 | Power state (1 = power saving, 0 = operating) |
| kbd_irq_o | output | 1 | Keyboard interrupt request (level) |
| wake_o | output | 1 | Wakeup request pulse to the power controller |

## Verification
The assertions assume that the interrupt enable, the power state and the write port are synchronous to the clock and change only between edges. The rows alone may be asynchronous. The stimulus drives every input at the falling edge, and it changes the mask, the power state or the mode only while the rows are held. Each row change is therefore judged against a settled previous state. Random row patterns are weighted toward all-zero and toward rows 6 and 7 alone, so that rising edges and the six-row exclusion occur often.

// File: rtl/kbd_wake_pkg.sv
package kbd_wake_pkg;

    localparam int unsigned SIX_ROW_BIT = 0;
    localparam int unsigned DWAKE_BIT   = 1;

    typedef struct packed {
        logic dwake;
        logic six_row;
    } kbd_ctrl_t;

endpackage

// File: rtl/kbd_ctrl_reg.sv
module kbd_ctrl_reg
    import kbd_wake_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output kbd_ctrl_t         ctrl_o
);

    typedef struct packed {
        kbd_ctrl_t ctrl;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.ctrl.six_row = wr_data_i[SIX_ROW_BIT];
            st_d.ctrl.dwake   = wr_data_i[DWAKE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o              = '0;
        rd_data_o[SIX_ROW_BIT] = st_q.ctrl.six_row;
        rd_data_o[DWAKE_BIT]   = st_q.ctrl.dwake;
    end

    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/kbd_row_sync.sv
module kbd_row_sync #(
    parameter int unsigned NROWS  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NROWS-1:0] row_i,
    output logic [NROWS-1:0] row_s_o
);

    typedef struct packed {
        logic [STAGES-1:0][NROWS-1:0] pipe;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = row_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign row_s_o = st_q.pipe[STAGES-1];

endmodule

// File: rtl/kbd_wake_gen.sv
module kbd_wake_gen
    import kbd_wake_pkg::*;
#(
    parameter int unsigned NROWS  = 8,
    parameter int unsigned NARROW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NROWS-1:0] row_s_i,
    input  kbd_ctrl_t        ctrl_i,
    input  logic             irq_en_i,
    input  logic             low_power_i,
    output logic             kbd_irq_o,
    output logic             wake_o
);

    logic [NROWS-1:0] narrow_mask;
    logic [NROWS-1:0] row_mask;
    logic             active;
    logic             src_now;

    for (genvar g = 0; g < NROWS; g++) begin : g_mask
        if (g < NARROW) begin : g_in
            assign narrow_mask[g] = 1'b1;
        end else begin : g_out
            assign narrow_mask[g] = 1'b0;
        end
    end

    typedef struct packed {
        logic src;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        row_mask = ctrl_i.six_row ? narrow_mask : '1;
        active   = |(row_s_i & row_mask);
        src_now  = ctrl_i.dwake ? active : (active & irq_en_i);
        st_d     = st_q;
        st_d.src = src_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kbd_irq_o = active & irq_en_i;
    assign wake_o    = low_power_i & src_now & ~st_q.src;

endmodule

// File: rtl/kbd_wake_ctrl.sv
module kbd_wake_ctrl
    import kbd_wake_pkg::*;
#(
    parameter int unsigned NROWS       = 8,
    parameter int unsigned NARROW      = 6,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NROWS-1:0]  row_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              irq_en_i,
    input  logic              low_power_i,
    output logic              kbd_irq_o,
    output logic              wake_o
);

    kbd_ctrl_t        ctrl;
    logic [NROWS-1:0] row_s;

    kbd_ctrl_reg #(.DATA_W(DATA_W)) i_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .ctrl_o    (ctrl)
    );

    kbd_row_sync #(.NROWS(NROWS), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_i   (row_i),
        .row_s_o (row_s)
    );

    kbd_wake_gen #(.NROWS(NROWS), .NARROW(NARROW)) i_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_s_i     (row_s),
        .ctrl_i      (ctrl),
        .irq_en_i    (irq_en_i),
        .low_power_i (low_power_i),
        .kbd_irq_o   (kbd_irq_o),
        .wake_o      (wake_o)
    );

endmodule

// File: rtl/kbd_wake_checker.sv
module kbd_wake_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_en_i,
    input logic              low_power_i,
    input logic              kbd_irq_o,
    input logic              wake_o
);

    // R9: bits above the two control bits always read zero
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DATA_W-1:2] == '0);

    // R9: a write lands on the next edge
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> rd_data_o[1:0] == $past(wr_data_i[1:0]));

    // R8: wakeup lasts one cycle
    a_r8_wake_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    // R8: no wakeup in the operating state
    a_r8_wake_needs_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> low_power_i);

    // R4: masked interrupt stays low
    a_r4_masked_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !kbd_irq_o);

    // R7: without direct wakeup, a wakeup comes with the interrupt request
    a_r7_wake_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !rd_data_o[1]) |-> kbd_irq_o);

endmodule

bind kbd_wake_ctrl kbd_wake_checker #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .rd_data_o   (rd_data_o),
    .irq_en_i    (irq_en_i),
    .low_power_i (low_power_i),
    .kbd_irq_o   (kbd_irq_o),
    .wake_o      (wake_o)
);

// File: tb/test_kbd_wake_ctrl.sv
`timescale 1ns/1ps
module test_kbd_wake_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] row_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_en_i = 1'b0;
    logic       low_power_i = 1'b0;
    logic       kbd_irq_o;
    logic       wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       m_six = 1'b0, m_dwake = 1'b0, m_ien = 1'b0, m_lp = 1'b0;

    always #2.5 clk = ~clk;

    kbd_wake_ctrl i_kbd_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .row_i(row_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_en_i(irq_en_i),
        .low_power_i(low_power_i), .kbd_irq_o(kbd_irq_o), .wake_o(wake_o)
    );

    function automatic logic act_f(logic [7:0] r, logic six);
        return six ? |r[5:0] : |r;
    endfunction

    function automatic logic src_f(logic [7:0] r, logic six, logic dw, logic ien);
        return dw ? act_f(r, six) : (act_f(r, six) & ien);
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_mode(logic six, logic dw, logic ien, logic lp);
        @(negedge clk);
        wr_en_i   = 1'b1;
        wr_data_i = {$urandom_range(63,0), dw, six};
        irq_en_i  = ien;
        low_power_i = lp;
        @(negedge clk);
        wr_en_i = 1'b0;
        m_six = six; m_dwake = dw; m_ien = ien; m_lp = lp;
        repeat (3) @(negedge clk);
        check("R9 readback", rd_data_o, {6'b0, dw, six});
    endtask

    // Rows are changed at a falling edge; two rising edges later the outputs follow (R10)
    task automatic apply_rows(logic [7:0] nr, string tag);
        logic [7:0] old = row_i;
        logic exp_irq  = act_f(nr, m_six) & m_ien;
        logic exp_wake = m_lp & src_f(nr, m_six, m_dwake, m_ien)
                         & ~src_f(old, m_six, m_dwake, m_ien);
        row_i = nr;
        @(negedge clk);
        check({tag, " R10 irq before 2 edges"}, {7'b0, kbd_irq_o}, {7'b0, act_f(old, m_six) & m_ien});
        @(negedge clk);
        check({tag, " irq"}, {7'b0, kbd_irq_o}, {7'b0, exp_irq});
        check({tag, " wake"}, {7'b0, wake_o}, {7'b0, exp_wake});
        @(negedge clk);
        check({tag, " R8 wake falls"}, {7'b0, wake_o}, 8'h0);
        check({tag, " irq level held"}, {7'b0, kbd_irq_o}, {7'b0, exp_irq});
    endtask

    initial begin
        void'($urandom(32'd20240601));
        repeat (3) @(negedge clk);
        check("R1 reset read", rd_data_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 read after reset", rd_data_o, 8'h00);
        check("R1 irq idle", {7'b0, kbd_irq_o}, 8'h0);

        // R2: eight-row mode, row 7 raises the interrupt
        set_mode(1'b0, 1'b0, 1'b1, 1'b0);
        apply_rows(8'h80, "R2 row7");
        apply_rows(8'h00, "R2 release");
        // R3: six-row mode ignores rows 6 and 7
        set_mode(1'b1, 1'b1, 1'b1, 1'b1);
        apply_rows(8'hC0, "R3 rows67 ignored");
        apply_rows(8'hE0, "R3 row5 counts");
        apply_rows(8'h00, "R3 release");
        // R5: direct wakeup while masked
        set_mode(1'b0, 1'b1, 1'b0, 1'b1);
        apply_rows(8'h01, "R5 masked wake");
        apply_rows(8'h00, "R5 release");
        // R6: direct wakeup unmasked
        set_mode(1'b0, 1'b1, 1'b1, 1'b1);
        apply_rows(8'h40, "R6 unmasked wake");
        apply_rows(8'h00, "R6 release");
        // R7: no direct wakeup, masked: nothing
        set_mode(1'b0, 1'b0, 1'b0, 1'b1);
        apply_rows(8'h10, "R7 masked no wake");
        apply_rows(8'h00, "R7 release");
        // R8: operating state, no wake
        set_mode(1'b0, 1'b1, 1'b1, 1'b0);
        apply_rows(8'h02, "R8 operating");
        apply_rows(8'h00, "R8 release");
        // R4: masked level stays low
        set_mode(1'b0, 1'b0, 1'b0, 1'b0);
        apply_rows(8'hFF, "R4 masked");
        apply_rows(8'h00, "R4 release");

        for (int i = 0; i < 300; i++) begin
            logic [7:0] nr;
            int pick = $urandom_range(3, 0);
            if (i % 8 == 0) begin
                set_mode($urandom_range(1,0), $urandom_range(1,0),
                         $urandom_range(1,0), $urandom_range(1,0));
            end
            case (pick)
                0: nr = 8'h00;
                1: nr = {$urandom_range(3,0), 6'b0};
                default: nr = 8'($urandom_range(255,0));
            endcase
            apply_rows(nr, "R2/R3/R5/R6/R7 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule